// File: doc/BRIEF.md
# Iterative Base-2 Logarithm Unit

This block takes a 24-bit floating-point operand and, over a number of clock cycles, returns its base-2 logarithm in the same 24-bit format. It works by multiplicative normalization. The mantissa starts in [1, 2). It is scaled down repeatedly by factors of the form (1 - 2^-k), for k from 2 up to 12. At each k, the scaling repeats for as long as the mantissa is at or above a per-step threshold. Every scaling adds the matching constant, -log2(1 - 2^-k) in 16-bit fixed point, to a fraction accumulator. When the last step is done, the signed input exponent supplies the integer part and the accumulator supplies the fraction. The sum is normalized into a float.

A caller pulses `start_i` with the operand on `op_i` and waits for the one-cycle `done_o` pulse. The unit then presents `res_o`, and it raises `cplx_o` when the logarithm would not be real, which is the case for a negative input. Both outputs hold their values until the next completion.

Top module: `log2_iter_unit`

## Requirements
- R1: Float format on `op_i` and `res_o`: bit 23 is the sign (1 = negative). Bits 22:16 are a two's-complement exponent e. Bits 15:0 are a mantissa m whose bit 15 carries weight 1. The value is (m / 2^15) * 2^e.
- R2: A start with bit 23 of `op_i` set yields `res_o` = 24'hFF0000 and `cplx_o` = 1, with `done_o` high in the cycle after the sampling edge.
- R3: A start with a non-negative operand yields `cplx_o` = 0 at its completion.
- R4: For k = 2..12 in increasing order, while m >= T(k), m becomes floor(p / 2^k) + bit (k-1) of p, where p = m * (2^k - 1). T(k) is AAAA, 9249, 8888, 8421, 8208, 8102, 8080, 8040, 8020, 8010, 8008 (hex) for k = 2..12.
- R5: Each scaling adds C(k) to a fraction accumulator that starts at zero. C(k) for k = 2..12 is 27200, 12625, 6102, 3002, 1489, 742, 370, 185, 92, 46, 23.
- R6: The result is formed from V = e * 65536 + accumulator. V = 0 gives 24'h000000. Otherwise, with P the index of the leading one of |V|, the sign bit is (V < 0), the exponent is P - 16, and the mantissa is |V| aligned so that bit P lands on bit 15, with low bits truncated. A non-zero result therefore has mantissa bit 15 set.
- R7: An input of exactly 1.0 (24'h008000) yields the exact result 24'h000000.
- R8: `done_o` is a single-cycle pulse. `res_o` and `cplx_o` change only in a cycle where `done_o` is high, and they hold otherwise.
- R9: A `start_i` pulse that arrives while a computation is in progress is ignored. It produces no extra completion and does not disturb the running result.
- R10: During reset `done_o`, `cplx_o` and `res_o` are zero.
- R11: Every computation completes within 48 cycles of its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a computation on `op_i` (sampled when idle) |
| op_i | input | 24 | Operand float |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | 24 | Result float |
| cplx_o | output | 1 | Result would be complex (negative operand) |

## Verification
Exact powers of two such as 1.0, 2.0, 0.5, 2^63 and 2^-64 produce no scaling at all, so they isolate the exponent-to-float packing: the sign, the leading-one search and the zero encoding. Mantissas spread across [1, 2), from just above 1.0 up to 0xFFFF, exercise single and repeated scalings at the different k. These results are compared against a bench-side model of the stepping and rounding rules, so an error in a threshold, a constant or the rounding bit shows up. A negative operand shows the short complex path. A second start issued mid-computation separates a unit that locks its operand from one that restarts or emits an extra completion.

// File: rtl/log2_pkg.sv
package log2_pkg;
  localparam int MW   = 16;           // mantissa width
  localparam int EW   = 7;            // exponent width
  localparam int FW   = 1 + EW + MW;  // float width
  localparam int AW   = MW + 1;       // fraction accumulator width
  localparam int KW   = 4;            // step index width
  localparam int KMIN = 2;
  localparam int KMAX = 12;

  localparam logic [FW-1:0] CPLX_MARK = {1'b1, {EW{1'b1}}, {MW{1'b0}}};

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  function automatic logic [MW-1:0] step_thr(input logic [KW-1:0] k);
    case (k)
      4'd2:    step_thr = 16'hAAAA;
      4'd3:    step_thr = 16'h9249;
      4'd4:    step_thr = 16'h8888;
      4'd5:    step_thr = 16'h8421;
      4'd6:    step_thr = 16'h8208;
      4'd7:    step_thr = 16'h8102;
      default: step_thr = 16'h8000 + (16'h8000 >> k);
    endcase
  endfunction

  function automatic logic [MW-1:0] step_cst(input logic [KW-1:0] k);
    case (k)
      4'd2:    step_cst = 16'd27200;
      4'd3:    step_cst = 16'd12625;
      4'd4:    step_cst = 16'd6102;
      4'd5:    step_cst = 16'd3002;
      4'd6:    step_cst = 16'd1489;
      4'd7:    step_cst = 16'd742;
      4'd8:    step_cst = 16'd370;
      4'd9:    step_cst = 16'd185;
      4'd10:   step_cst = 16'd92;
      4'd11:   step_cst = 16'd46;
      4'd12:   step_cst = 16'd23;
      default: step_cst = 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/log2_scale_step.sv
module log2_scale_step
  import log2_pkg::*;
(
  input  logic [MW-1:0] mant_i,
  input  logic [KW-1:0] k_i,
  output logic          ge_o,
  output logic [MW-1:0] mant_o,
  output logic [MW-1:0] cst_o
);
  localparam int PW = MW + KMAX;

  logic [PW-1:0] prod;

  // prod = m * (2^k - 1)
  assign prod   = (PW'(mant_i) << k_i) - PW'(mant_i);
  assign ge_o   = mant_i >= step_thr(k_i);
  assign mant_o = MW'((prod >> k_i) + PW'(prod[k_i - 4'd1]));
  assign cst_o  = step_cst(k_i);
endmodule

// File: rtl/log2_pack.sv
module log2_pack
  import log2_pkg::*;
(
  input  logic [EW-1:0] exp_i,
  input  logic [AW-1:0] acc_i,
  output logic [FW-1:0] res_o
);
  localparam int VW = EW + MW + 2;

  logic signed [VW-1:0] val;
  logic [VW-1:0]        mag;
  logic [MW-1:0]        mant;
  logic [EW-1:0]        ex;
  int                   lead;

  always_comb begin
    val = $signed({{2{exp_i[EW-1]}}, exp_i, {MW{1'b0}}})
        + $signed({{(VW-AW){1'b0}}, acc_i});
    mag = val[VW-1] ? VW'(-val) : VW'(val);
    lead = 0;
    for (int i = 0; i < VW; i++) if (mag[i]) lead = i;
    if (lead >= MW - 1) mant = MW'(mag >> (lead - (MW - 1)));
    else                mant = MW'(mag << ((MW - 1) - lead));
    ex    = EW'(lead - MW);
    res_o = (mag == '0) ? '0 : {val[VW-1], ex, mant};
  end
endmodule

// File: rtl/log2_iter_unit.sv
module log2_iter_unit
  import log2_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [23:0]   op_i,
  output logic          done_o,
  output logic [23:0]   res_o,
  output logic          cplx_o
);
  state_e        state_q;
  logic [MW-1:0] m_q;
  logic [EW-1:0] e_q;
  logic [AW-1:0] acc_q;
  logic [KW-1:0] k_q;
  logic [FW-1:0] res_q;
  logic          cplx_q, done_q;

  logic          ge;
  logic [MW-1:0] m_nxt, cst;
  logic [FW-1:0] packed_res;

  log2_scale_step u_step (
    .mant_i (m_q),
    .k_i    (k_q),
    .ge_o   (ge),
    .mant_o (m_nxt),
    .cst_o  (cst)
  );

  log2_pack u_pack (
    .exp_i (e_q),
    .acc_i (acc_q),
    .res_o (packed_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      m_q     <= '0;
      e_q     <= '0;
      acc_q   <= '0;
      k_q     <= KW'(KMIN);
      res_q   <= '0;
      cplx_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (op_i[FW-1]) begin
            res_q  <= CPLX_MARK;
            cplx_q <= 1'b1;
            done_q <= 1'b1;
          end else begin
            m_q     <= op_i[MW-1:0];
            e_q     <= op_i[FW-2:MW];
            acc_q   <= '0;
            k_q     <= KW'(KMIN);
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (ge) begin
            m_q   <= m_nxt;
            acc_q <= acc_q + AW'(cst);
          end else if (k_q == KW'(KMAX)) begin
            res_q   <= packed_res;
            cplx_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign res_o  = res_q;
  assign cplx_o = cplx_q;
endmodule

// File: rtl/log2_iter_chk.sv
module log2_iter_chk #(
  parameter int LAT_MAX = 48
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [23:0] op_i,
  input logic        done_o,
  input logic [23:0] res_o,
  input logic        cplx_o
);
  logic       busy_q;
  logic [7:0] cnt_q;
  logic       accept;

  assign accept = start_i && (!busy_q || done_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept && !op_i[23]) begin
      busy_q <= 1'b1;
      cnt_q  <= 8'd1;
    end else if (done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q && cnt_q != 8'hFF) begin
      cnt_q <= cnt_q + 8'd1;
    end
  end

  p_marker_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && cplx_o |-> res_o == 24'hFF0000);

  p_neg_fast_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && op_i[23] |=> done_o && cplx_o);

  p_norm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !cplx_o && res_o != 24'h0 |-> res_o[15]);

  p_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(res_o) && $stable(cplx_o));

  p_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= 8'(LAT_MAX));
endmodule

bind log2_iter_unit log2_iter_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_i    (op_i),
  .done_o  (done_o),
  .res_o   (res_o),
  .cplx_o  (cplx_o)
);

// File: tb/sim_log2_iter_unit.sv
module sim_log2_iter_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_MAX    = 48;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] op = '0;
  logic        done;
  logic [23:0] res;
  logic        cplx;

  int checks = 0;
  int fails  = 0;
  int n_done = 0;
  logic [24:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  log2_iter_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .done_o(done), .res_o(res), .cplx_o(cplx)
  );

  function automatic logic [24:0] model(input logic [23:0] x);
    int thr[13] = '{0, 0, 'hAAAA, 'h9249, 'h8888, 'h8421, 'h8208, 'h8102,
                    'h8080, 'h8040, 'h8020, 'h8010, 'h8008};
    int cst[13] = '{0, 0, 27200, 12625, 6102, 3002, 1489, 742, 370, 185, 92, 46, 23};
    longint m, p, v, mag, mant;
    int acc, lead, e;
    if (x[23]) return {1'b1, 24'hFF0000};
    m = longint'(x[15:0]);
    acc = 0;
    for (int k = 2; k <= 12; k++) begin
      while (m >= thr[k]) begin
        p = m * ((64'd1 << k) - 1);
        m = (p >> k) + ((p >> (k - 1)) & 1);
        acc += cst[k];
      end
    end
    e = int'($signed(x[22:16]));
    v = longint'(e) * 65536 + acc;
    if (v == 0) return 25'h0;
    mag = (v < 0) ? -v : v;
    lead = 0;
    for (int i = 0; i < 40; i++) if (mag[i]) lead = i;
    mant = (lead >= 15) ? (mag >> (lead - 15)) : (mag << (15 - lead));
    return {1'b0, (v < 0), 7'(lead - 16), mant[15:0]};
  endfunction

  // monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected completion res=%h cplx=%0d expected none", res, cplx);
      end else begin
        logic [24:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({cplx, res} !== e) begin
          fails++;
          $display("FAIL %s res=%h cplx=%0d expected res=%h cplx=%0d",
                   t, res, cplx, e[23:0], e[24]);
        end
      end
    end
  end

  task automatic run_op(input logic [23:0] x, input string tag, input bit extra_start);
    int base, cyc;
    exp_q.push_back(model(x));
    tag_q.push_back(tag);
    base = n_done;
    @(negedge clk);
    op = x;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (extra_start) begin
      repeat (3) @(negedge clk);
      cyc += 3;
      op = 24'h00C123;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      op = '0;
      cyc++;
    end
    while (n_done == base && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    checks++;
    if (cyc > LAT_MAX) begin
      fails++;
      $display("FAIL R11 %s latency=%0d expected <= %0d", tag, cyc, LAT_MAX);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0 || res !== 24'h0 || cplx !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset done=%0d res=%h cplx=%0d expected 0 0 0", done, res, cplx);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_op(24'h008000, "R7 one gives zero", 1'b0);
    checks++;
    if (res !== 24'h000000) begin
      fails++;
      $display("FAIL R7 res=%h expected 000000", res);
    end
    run_op(24'h018000, "R6 two gives 1.0", 1'b0);
    checks++;
    if (res !== 24'h008000) begin
      fails++;
      $display("FAIL R6 res=%h expected 008000", res);
    end
    run_op(24'h7F8000, "R1 half gives -1.0", 1'b0);
    checks++;
    if (res !== 24'h808000) begin
      fails++;
      $display("FAIL R1 res=%h expected 808000", res);
    end
    run_op(24'h3F8000, "R6 max exponent", 1'b0);
    run_op(24'h408000, "R6 min exponent", 1'b0);
    run_op(24'h80C000, "R2 negative marker", 1'b0);
    checks++;
    if (cplx !== 1'b1 || res !== 24'hFF0000) begin
      fails++;
      $display("FAIL R2 res=%h cplx=%0d expected FF0000 1", res, cplx);
    end
    run_op(24'h00C000, "R3 one and a half", 1'b0);
    checks++;
    if (cplx !== 1'b0) begin
      fails++;
      $display("FAIL R3 cplx=%0d expected 0", cplx);
    end
    run_op(24'h00FFFF, "R4 top mantissa repeats k2", 1'b0);
    run_op(24'h008009, "R4 just above 1 hits k12", 1'b0);
    run_op(24'h00AAAA, "R4 at k2 threshold", 1'b0);
    run_op(24'h00AAA9, "R4 below k2 threshold", 1'b0);
    run_op(24'h05B504, "R5 sqrt2 scaled", 1'b0);
    run_op(24'h7DE123, "R5 negative log", 1'b0);
    run_op(24'h0A9ABC, "R5 mid mantissa", 1'b0);
    run_op(24'h018421, "R4 at k5 threshold", 1'b0);
    run_op(24'h00D2F1, "R9 start during run ignored", 1'b1);
    // R8: outputs hold after completion
    begin
      logic [23:0] r0;
      r0 = res;
      repeat (5) @(negedge clk);
      checks++;
      if (res !== r0 || done !== 1'b0) begin
        fails++;
        $display("FAIL R8 res=%h done=%0d expected %h 0", res, done, r0);
      end
    end
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9 pending=%0d expected 0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule